// File: doc/BRIEF.md
# Programmable Baud-Rate Generator with Shared-Address Divisor Latches

This block makes the timing strobe for a serial port. A 16-bit divisor sits in two byte-wide latches. A down-counter divides the input clock by that divisor. It emits a single-cycle `baud_tick` pulse once per divisor period. The pulse rate is sixteen times the serial bit rate. With a 1.8432 MHz input clock, a divisor of 12 gives a 9600-baud link.

Software reaches the block through a small synchronous register port. It has a 3-bit offset, single-cycle write and read strobes, and byte data. The divisor bytes have no offsets of their own. They overlay the data-buffer offset and the interrupt-enable offset. A divisor-access bit in the line control byte chooses which of the two registers those offsets reach. When that bit is clear, offset 0 talks to the serial datapath:
- A write there is passed out to the transmitter as a strobe plus a byte.
- A read there returns the receiver's byte and raises a read strobe.

The shifter sends and receives least significant bit first, but the shifter itself lies outside this block.

When either divisor byte is written, the counter restarts from the new divisor on the same clock edge. It does not wait for the running count to finish.

Top module: `ubg_top`

## Requirements
- R1: After synchronous reset, the following are all zero:
  - both divisor bytes;
  - the line control byte;
  - the interrupt-enable byte;
  - the counter.

  `baud_tick` is low, and it stays low until a nonzero divisor is written.
- R2: Offset 3 always reaches the 8-bit line control byte, for both read and write. Its bit 7 is the divisor-access bit. All eight bits are presented on `line_ctl`.
- R3: With bit 7 of the line control byte set, offsets 0 and 1 reach the low and high divisor bytes. Reads return the stored bytes.
- R4: With the access bit clear, a write to offset 0 has these effects:
  - `tx_wr` pulses in that cycle, with `tx_data` equal to the written byte.
  - The divisor does not change.
- R4 (read side): With the access bit clear, a read of offset 0 returns `rx_byte`.
- R5: With the access bit clear, offset 1 reaches the 8-bit interrupt-enable byte, which is presented on `int_en`. Writing it leaves the divisor unchanged.
- R6: For a nonzero divisor D, `baud_tick` is high for exactly one cycle in every D cycles. With D = 1, it is high on every cycle.
- R7: A write to either divisor byte reloads the counter on that edge. The next pulse appears exactly D cycles after the write, whatever the phase of the old count.
- R8: With a divisor of 0, the counter holds and no pulse is produced.
- R9: When a divisor write falls in the cycle where the counter would expire, the reload wins and no pulse is produced for that expiry.
- R10: Offsets 2, 4, 5, 6 and 7 read as 0. Writes to them change no state.
- R11: `rx_rd` pulses only in the cycle of a read of offset 0 with the access bit clear. No other read or write has a side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all logic is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| rdata | output | 8 | Read data for the selected register (combinational) |
| rx_byte | input | 8 | Byte held by the receiver, returned on data reads |
| rx_rd | output | 1 | Pulses when the receive byte is read |
| tx_wr | output | 1 | Pulses when a byte is written for transmission |
| tx_data | output | 8 | Byte handed to the transmitter with `tx_wr` |
| line_ctl | output | 8 | Current line control byte |
| int_en | output | 8 | Current interrupt-enable byte |
| baud_tick | output | 1 | One-cycle strobe at sixteen times the bit rate |

## Verification
A divisor write and counter expiry can land on the same clock edge. The bench provokes this collision deliberately: it rewrites the low divisor byte after idle gaps of every length from zero to beyond the period, so one of those writes lands exactly on the expiring cycle. Its cycle-by-cycle model gives precedence to the reload. Each cycle it compares `baud_tick` against that model, so a pulse leaking through the collision is reported under R9. A late restart is reported under R7.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

    localparam int UBG_ADDR_W     = 3;
    localparam int UBG_DATA_W     = 8;
    localparam int UBG_OFS_DATA   = 0;
    localparam int UBG_OFS_IEN    = 1;
    localparam int UBG_OFS_LCTL   = 3;
    localparam int UBG_ACCESS_BIT = 7;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_IEN   = 3'd2,
        SEL_DIVLO = 3'd3,
        SEL_DIVHI = 3'd4,
        SEL_LCTL  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic                  wr;
        logic                  rd;
        reg_sel_e              sel;
        logic [UBG_DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic is_div_sel(reg_sel_e s);
        return (s == SEL_DIVLO) || (s == SEL_DIVHI);
    endfunction

endpackage

// File: rtl/ubg_decode.sv
module ubg_decode
    import ubg_pkg::*;
#(
    parameter int ADDR_W = UBG_ADDR_W
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [UBG_DATA_W-1:0] wdata,
    input  logic                  access,
    output bus_req_t              req
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(UBG_OFS_DATA);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(UBG_OFS_IEN);
    localparam logic [ADDR_W-1:0] A_LCTL = ADDR_W'(UBG_OFS_LCTL);

    reg_sel_e sel;

    always_comb begin
        if (addr == A_DATA) begin
            sel = access ? SEL_DIVLO : SEL_DATA;
        end else if (addr == A_IEN) begin
            sel = access ? SEL_DIVHI : SEL_IEN;
        end else if (addr == A_LCTL) begin
            sel = SEL_LCTL;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        req.wr    = wr_en;
        req.rd    = rd_en;
        req.sel   = sel;
        req.wdata = wdata;
    end

endmodule

// File: rtl/ubg_regs.sv
module ubg_regs
    import ubg_pkg::*;
#(
    parameter int DATA_W = UBG_DATA_W,
    localparam int DIV_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] rdata,
    output logic              rx_rd,
    output logic              tx_wr,
    output logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] line_ctl,
    output logic [DATA_W-1:0] int_en,
    output logic              access,
    output logic [DIV_W-1:0]  divisor,
    output logic              div_load,
    output logic [DIV_W-1:0]  div_next
);

    logic [DATA_W-1:0] div_lo_q, div_hi_q, lctl_q, ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_lo_q <= '0;
            div_hi_q <= '0;
            lctl_q   <= '0;
            ien_q    <= '0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_DIVLO: div_lo_q <= req.wdata;
                SEL_DIVHI: div_hi_q <= req.wdata;
                SEL_IEN:   ien_q    <= req.wdata;
                SEL_LCTL:  lctl_q   <= req.wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (req.sel)
            SEL_DATA:  rdata = rx_byte;
            SEL_IEN:   rdata = ien_q;
            SEL_DIVLO: rdata = div_lo_q;
            SEL_DIVHI: rdata = div_hi_q;
            SEL_LCTL:  rdata = lctl_q;
            default:   rdata = '0;
        endcase
    end

    assign tx_wr    = req.wr && (req.sel == SEL_DATA);
    assign tx_data  = req.wdata;
    assign rx_rd    = req.rd && (req.sel == SEL_DATA);
    assign line_ctl = lctl_q;
    assign int_en   = ien_q;
    assign access   = lctl_q[UBG_ACCESS_BIT];
    assign divisor  = {div_hi_q, div_lo_q};
    assign div_load = req.wr && is_div_sel(req.sel);
    assign div_next = (req.sel == SEL_DIVLO) ? {div_hi_q, req.wdata}
                                             : {req.wdata, div_lo_q};

    AST_TX_KEEPS_DIV: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> $stable(divisor)); // R4
    AST_IEN_KEEPS_DIV: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_IEN) |=> $stable(divisor)); // R5
    AST_RXRD_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rx_rd |-> !access); // R11
    AST_NONE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_NONE) |=>
            ($stable(divisor) && $stable(lctl_q) && $stable(ien_q))); // R10

endmodule

// File: rtl/ubg_counter.sv
module ubg_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_val;
            tick_q <= 1'b0;
        end else if (divisor == '0) begin
            tick_q <= 1'b0;
        end else if (cnt_q <= ONE) begin
            cnt_q  <= divisor;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - ONE;
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val))); // R7
    AST_LOAD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        load |=> !tick); // R9
    AST_ZERO_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && divisor == '0) |=> (!tick && $stable(cnt_q))); // R8
    AST_TICK_RELOADS: assert property (@(posedge clk) disable iff (rst)
        tick |-> (cnt_q == divisor)); // R6

endmodule

// File: rtl/ubg_top.sv
module ubg_top
    import ubg_pkg::*;
#(
    parameter int ADDR_W = UBG_ADDR_W,
    parameter int DATA_W = UBG_DATA_W,
    localparam int DIV_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_rd,
    output logic              tx_wr,
    output logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] line_ctl,
    output logic [DATA_W-1:0] int_en,
    output logic              baud_tick
);

    bus_req_t         req;
    logic             access;
    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] div_next;
    logic             div_load;

    ubg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wdata  (wdata),
        .access (access),
        .req    (req)
    );

    ubg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .rx_byte  (rx_byte),
        .rdata    (rdata),
        .rx_rd    (rx_rd),
        .tx_wr    (tx_wr),
        .tx_data  (tx_data),
        .line_ctl (line_ctl),
        .int_en   (int_en),
        .access   (access),
        .divisor  (divisor),
        .div_load (div_load),
        .div_next (div_next)
    );

    ubg_counter #(.DIV_W(DIV_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .load_val (div_next),
        .divisor  (divisor),
        .tick     (baud_tick)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!baud_tick && line_ctl == '0 && int_en == '0)); // R1

endmodule

// File: tb/sim_ubg_top.sv
`timescale 1ns/1ps
module sim_ubg_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] rdata, tx_data, line_ctl, int_en;
    logic       rx_rd, tx_wr, baud_tick;

    always #4 clk = ~clk;

    ubg_top u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .rx_byte(rx_byte), .rx_rd(rx_rd),
        .tx_wr(tx_wr), .tx_data(tx_data), .line_ctl(line_ctl),
        .int_en(int_en), .baud_tick(baud_tick)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int m_lo, m_hi, m_lcr, m_ien, m_cnt, m_since;
    bit m_tick, m_prev_load;

    function automatic int m_div();
        return m_hi * 256 + m_lo;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_lo = 0; m_hi = 0; m_lcr = 0; m_ien = 0; m_cnt = 0;
            m_tick = 0; m_prev_load = 0; m_since = 0;
        end else begin
            bit acc, ld;
            acc = m_lcr[7];
            ld  = wr_en && acc && (addr == 3'd0 || addr == 3'd1);
            if (wr_en) begin
                if (addr == 3'd3) m_lcr = wdata;
                else if (addr == 3'd0 && acc) m_lo = wdata;
                else if (addr == 3'd1 && acc) m_hi = wdata;
                else if (addr == 3'd1) m_ien = wdata;
            end
            if (ld) begin
                m_cnt = m_div(); m_tick = 0; m_since = 0;
            end else if (m_div() == 0) begin
                m_tick = 0;
            end else if (m_cnt <= 1) begin
                m_cnt = m_div(); m_tick = 1; m_since = m_since + 1;
            end else begin
                m_cnt = m_cnt - 1; m_tick = 0; m_since = m_since + 1;
            end
            m_prev_load = ld;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit acc;
        int exp_rd;
        string tag;
        acc = m_lcr[7];
        if (m_prev_load) tag = "R9";
        else if (m_div() == 0) tag = "R8";
        else if (m_since <= m_div()) tag = "R7";
        else tag = "R6";
        check(baud_tick == m_tick, {tag, " baud_tick"}, baud_tick, m_tick);
        check(tx_wr == (wr_en && !acc && addr == 3'd0), "R4 tx_wr", tx_wr,
              wr_en && !acc && addr == 3'd0);
        if (tx_wr) check(tx_data == wdata, "R4 tx_data", tx_data, wdata);
        check(rx_rd == (rd_en && !acc && addr == 3'd0), "R11 rx_rd", rx_rd,
              rd_en && !acc && addr == 3'd0);
        check(line_ctl == m_lcr[7:0], "R2 line_ctl", line_ctl, m_lcr);
        check(int_en == m_ien[7:0], "R5 int_en", int_en, m_ien);
        if (rd_en) begin
            case (addr)
                3'd0: begin exp_rd = acc ? m_lo : rx_byte; tag = acc ? "R3" : "R4"; end
                3'd1: begin exp_rd = acc ? m_hi : m_ien;   tag = acc ? "R3" : "R5"; end
                3'd3: begin exp_rd = m_lcr;                tag = "R2"; end
                default: begin exp_rd = 0;                 tag = "R10"; end
            endcase
            check(rdata == exp_rd[7:0], {tag, " rdata"}, rdata, exp_rd);
        end
    endtask

    task automatic step(bit w, bit r, logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #2;
        compare();
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d); step(1, 0, a, d); endtask
    task automatic rd(logic [2:0] a);               step(0, 1, a, 8'h00); endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state
        #2;
        check(baud_tick == 0, "R1 tick after reset", baud_tick, 0);
        check(line_ctl == 0, "R1 line_ctl after reset", line_ctl, 0);
        check(int_en == 0, "R1 int_en after reset", int_en, 0);
        idle(20);                       // R1/R8: no pulses with zero divisor
        wr(3'd3, 8'h83); rd(3'd3);      // R2
        rd(3'd0); rd(3'd1);             // R3: divisor reads zero
        wr(3'd0, 8'd4); wr(3'd1, 8'd0); // R3/R7
        rd(3'd0); rd(3'd1);
        idle(20);                       // R6 period 4
        wr(3'd3, 8'h03);                // clear access bit
        rx_byte = 8'hC3;
        wr(3'd0, 8'h5A); rd(3'd0);      // R4, R11
        wr(3'd1, 8'hA5); rd(3'd1);      // R5
        idle(10);                       // divisor untouched: period still 4
        wr(3'd2, 8'hFF); rd(3'd2);      // R10
        wr(3'd5, 8'h77); rd(3'd5);
        wr(3'd7, 8'h11); rd(3'd7);
        rd(3'd4); rd(3'd6);
        rd(3'd3);
        wr(3'd3, 8'h80);
        rd(3'd0); rd(3'd1); rd(3'd2);   // R11: no rx_rd when access set
        wr(3'd0, 8'd1); idle(10);       // R6 D=1
        wr(3'd0, 8'd7); idle(12);
        for (int k = 0; k < 10; k++) begin   // R7/R9 collision sweep
            idle(k);
            wr(3'd0, 8'd5);
        end
        idle(12);
        wr(3'd0, 8'd0); wr(3'd1, 8'd1); // D=256 via high byte, R7
        idle(600);
        wr(3'd1, 8'd0); idle(30);       // R8 divisor zero
        wr(3'd0, 8'd3); idle(10);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule